// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This block is the logic of a single pad. It lets a pin act as an input, an output, or both. On the drive side it chooses between a normally routed data bit and a faster bypass data bit, and it can invert the result. It then drives the pin under an output enable chosen from several sources. The pin can be driven as totem-pole or as logical open-drain. On the receive side it returns the pin value to the routing fabric in one of three ways: directly, through an edge register, or through a level-sensitive latch. The register and the latch run on one of two I/O clocks, chosen per cell.

The output enable can be held off or on, or it can follow a global enable. It can also follow a group enable, which an internal selector picks from the product-term enables of the eight logic blocks that share the cell's group. An active-low global reset clears the stored input value at any time. The receive path keeps working while the cell drives the pin, so a bidirectional cell reads back its own output.

The pin is modelled as three signals: `padIn` from the pin, `padOut` towards the pin, and `padOe` as the pin driver enable.

Top module: `iocell_top`

## Requirements
- R1: When `cfgUseBypass` is 1 the drive data is `bypassData`, otherwise it is `routedData`.
- R2: When `cfgInvert` is 1 the drive data is inverted before it reaches the pin.
- R3: `cfgOeSel` selects the enable. Code 0 disables the output and code 1 enables it. Code 2 uses the group enable, code 3 uses `goe0` and code 4 uses `goe1`. Codes 5 to 7 disable the output.
- R4: The group enable equals bit `cfgPtSel` of `ptOeTerms`.
- R5: With `cfgOpenDrain` at 0 (totem-pole), `padOut` equals the drive data and `padOe` equals the selected enable.
- R6: With `cfgOpenDrain` at 1, `padOut` is 0. `padOe` is 1 only when the enable is 1 and the drive data is 0.
- R7: `cfgInMode` selects the input path. Codes 0 and 3 give `toRouting` = `padIn` combinationally. Code 1 selects the edge register and code 2 selects the latch.
- R8: The edge register samples `padIn` on each rising edge of the selected clock and holds it between edges. `cfgClkSel` 0 selects `ioClk0` and 1 selects `ioClk1`.
- R9: The latch follows `padIn` while the selected clock is high and holds its value while the clock is low.
- R10: While `rstN` is low, the register and the latch read 0. The clear takes effect at once, without waiting for a clock edge.
- R11: The input path reflects `padIn` regardless of `padOe`, so a driving cell reads back the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ioClk0 | input | 1 | I/O clock 0 |
| ioClk1 | input | 1 | I/O clock 1 |
| rstN | input | 1 | Active-low global reset, asynchronous |
| routedData | input | 1 | Normal routed drive data |
| bypassData | input | 1 | Fast bypass drive data |
| ptOeTerms | input | NUM_TERMS | Product-term enables of the group's logic blocks |
| goe0 | input | 1 | Global output enable 0 |
| goe1 | input | 1 | Global output enable 1 |
| cfgUseBypass | input | 1 | Select bypass data |
| cfgInvert | input | 1 | Invert drive data |
| cfgOpenDrain | input | 1 | Open-drain drive mode |
| cfgOeSel | input | 3 | Enable source code |
| cfgPtSel | input | SEL_W | Group enable term index |
| cfgClkSel | input | 1 | Input storage clock select |
| cfgInMode | input | 2 | Input path mode |
| padIn | input | 1 | Value seen on the pin |
| padOut | output | 1 | Value driven to the pin |
| padOe | output | 1 | Pin driver enable |
| toRouting | output | 1 | Input value returned to routing |

## Verification
A wrong drive-side decode shows on `padOut` or `padOe` in the same cycle as the configuration that exposes it. A bad polarity, data source or enable code therefore mismatches in the first vector that uses it. A wrong storage state shows on `toRouting` only while the register or latch mode is selected. It appears after the next edge of the selected clock for the register, or at the next high phase for the latch. For that reason the configuration is changed often, and the pin is also driven while the clock is high so that transparency can be told apart from edge capture.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

  localparam logic [2:0] OE_CODE_OFF  = 3'd0;
  localparam logic [2:0] OE_CODE_ON   = 3'd1;
  localparam logic [2:0] OE_CODE_GRP  = 3'd2;
  localparam logic [2:0] OE_CODE_GLB0 = 3'd3;
  localparam logic [2:0] OE_CODE_GLB1 = 3'd4;

  typedef enum logic [1:0] {
    IN_COMB     = 2'd0,
    IN_EDGE     = 2'd1,
    IN_LEVEL    = 2'd2,
    IN_COMB_ALT = 2'd3
  } inMode_e;

  typedef struct packed {
    logic    oeActive;
    logic    useBypass;
    logic    invert;
    logic    openDrain;
    logic    clkSel;
    inMode_e inMode;
  } cellStrobe_t;

endpackage

// File: rtl/iocell_ctrl.sv
module iocell_ctrl
  import iocell_pkg::*;
#(
  parameter int NUM_TERMS = 8,
  localparam int SEL_W = (NUM_TERMS > 1) ? $clog2(NUM_TERMS) : 1,
  localparam int PAD_TERMS = 1 << SEL_W
) (
  input  logic                 ioClk0,
  input  logic                 rstN,
  input  logic [NUM_TERMS-1:0] ptOeTerms,
  input  logic                 goe0,
  input  logic                 goe1,
  input  logic                 cfgUseBypass,
  input  logic                 cfgInvert,
  input  logic                 cfgOpenDrain,
  input  logic [2:0]           cfgOeSel,
  input  logic [SEL_W-1:0]     cfgPtSel,
  input  logic                 cfgClkSel,
  input  logic [1:0]           cfgInMode,
  output cellStrobe_t          strobe
);

  logic [PAD_TERMS-1:0] termsPadded;
  logic                 groupOe;
  logic                 oeSel;

  generate
    if (PAD_TERMS == NUM_TERMS) begin : g_exact
      assign termsPadded = ptOeTerms;
    end else begin : g_padded
      assign termsPadded = {{(PAD_TERMS-NUM_TERMS){1'b0}}, ptOeTerms};
    end
  endgenerate

  assign groupOe = termsPadded[cfgPtSel];

  always_comb begin
    case (cfgOeSel)
      OE_CODE_ON:   oeSel = 1'b1;
      OE_CODE_GRP:  oeSel = groupOe;
      OE_CODE_GLB0: oeSel = goe0;
      OE_CODE_GLB1: oeSel = goe1;
      default:      oeSel = 1'b0;
    endcase
  end

  always_comb begin
    strobe.oeActive  = oeSel;
    strobe.useBypass = cfgUseBypass;
    strobe.invert    = cfgInvert;
    strobe.openDrain = cfgOpenDrain;
    strobe.clkSel    = cfgClkSel;
    strobe.inMode    = inMode_e'(cfgInMode);
  end

  // R3: codes outside 1..4 never enable the driver
  p_oe_unused_off_r3: assert property (@(posedge ioClk0) disable iff (!rstN)
    (cfgOeSel == OE_CODE_OFF || cfgOeSel > OE_CODE_GLB1) |-> !strobe.oeActive);

  // R3: global enable 1 path
  p_goe1_follow_r3: assert property (@(posedge ioClk0) disable iff (!rstN)
    (cfgOeSel == OE_CODE_GLB1) |-> (strobe.oeActive == goe1));

  // R4: group enable reflects the indexed term
  p_group_pick_r4: assert property (@(posedge ioClk0) disable iff (!rstN)
    (cfgOeSel == OE_CODE_GRP && $onehot0(ptOeTerms) && ptOeTerms == '0) |-> !strobe.oeActive);

endmodule

// File: rtl/iocell_dp.sv
module iocell_dp
  import iocell_pkg::*;
(
  input  logic        ioClk0,
  input  logic        ioClk1,
  input  logic        rstN,
  input  cellStrobe_t strobe,
  input  logic        routedData,
  input  logic        bypassData,
  input  logic        padIn,
  output logic        padOut,
  output logic        padOe,
  output logic        toRouting
);

  logic srcData;
  logic polData;
  logic selClk;
  logic edgeQ;
  logic levelQ;

  // drive side
  assign srcData = strobe.useBypass ? bypassData : routedData;
  assign polData = srcData ^ strobe.invert;

  always_comb begin
    if (strobe.openDrain) begin
      padOut = 1'b0;
      padOe  = strobe.oeActive & ~polData;
    end else begin
      padOut = polData;
      padOe  = strobe.oeActive;
    end
  end

  // receive side
  assign selClk = strobe.clkSel ? ioClk1 : ioClk0;

  always_ff @(posedge selClk or negedge rstN) begin
    if (!rstN) edgeQ <= 1'b0;
    else       edgeQ <= padIn;
  end

  always_latch begin
    if (!rstN)       levelQ = 1'b0;
    else if (selClk) levelQ = padIn;
  end

  always_comb begin
    case (strobe.inMode)
      IN_EDGE:  toRouting = edgeQ;
      IN_LEVEL: toRouting = levelQ;
      default:  toRouting = padIn;
    endcase
  end

  // R5: no drive without an enable from control
  p_no_drive_r5: assert property (@(posedge ioClk0) disable iff (!rstN)
    !strobe.oeActive |-> !padOe);

  // R6: open-drain never drives a high level
  p_od_low_only_r6: assert property (@(posedge ioClk0) disable iff (!rstN)
    (strobe.openDrain && padOe) |-> (padOut == 1'b0 && polData == 1'b0));

  // R7 / R11: direct path tracks the pin even while driving
  p_direct_r7: assert property (@(posedge ioClk0) disable iff (!rstN)
    (strobe.inMode == IN_COMB || strobe.inMode == IN_COMB_ALT) |-> (toRouting == padIn));

  // R8: edge register on clock 0 presents the value sampled at the previous edge
  p_edge_cap_r8: assert property (@(posedge ioClk0) disable iff (!rstN)
    (strobe.inMode == IN_EDGE && !strobe.clkSel)
      ##1 (strobe.inMode == IN_EDGE && !strobe.clkSel && $past(rstN))
      |-> (toRouting == $past(padIn)));

  // R10: stored value cleared while reset is held
  p_reset_clear_r10: assert property (@(posedge ioClk0)
    (!rstN && $past(!rstN) && (strobe.inMode == IN_EDGE || strobe.inMode == IN_LEVEL))
      |-> (toRouting == 1'b0));

endmodule

// File: rtl/iocell_top.sv
module iocell_top
  import iocell_pkg::*;
#(
  parameter int NUM_TERMS = 8,
  localparam int SEL_W = (NUM_TERMS > 1) ? $clog2(NUM_TERMS) : 1
) (
  input  logic                 ioClk0,
  input  logic                 ioClk1,
  input  logic                 rstN,
  input  logic                 routedData,
  input  logic                 bypassData,
  input  logic [NUM_TERMS-1:0] ptOeTerms,
  input  logic                 goe0,
  input  logic                 goe1,
  input  logic                 cfgUseBypass,
  input  logic                 cfgInvert,
  input  logic                 cfgOpenDrain,
  input  logic [2:0]           cfgOeSel,
  input  logic [SEL_W-1:0]     cfgPtSel,
  input  logic                 cfgClkSel,
  input  logic [1:0]           cfgInMode,
  input  logic                 padIn,
  output logic                 padOut,
  output logic                 padOe,
  output logic                 toRouting
);

  cellStrobe_t strobe;

  iocell_ctrl #(.NUM_TERMS(NUM_TERMS)) u_ctrl (
    .ioClk0       (ioClk0),
    .rstN         (rstN),
    .ptOeTerms    (ptOeTerms),
    .goe0         (goe0),
    .goe1         (goe1),
    .cfgUseBypass (cfgUseBypass),
    .cfgInvert    (cfgInvert),
    .cfgOpenDrain (cfgOpenDrain),
    .cfgOeSel     (cfgOeSel),
    .cfgPtSel     (cfgPtSel),
    .cfgClkSel    (cfgClkSel),
    .cfgInMode    (cfgInMode),
    .strobe       (strobe)
  );

  iocell_dp u_dp (
    .ioClk0     (ioClk0),
    .ioClk1     (ioClk1),
    .rstN       (rstN),
    .strobe     (strobe),
    .routedData (routedData),
    .bypassData (bypassData),
    .padIn      (padIn),
    .padOut     (padOut),
    .padOe      (padOe),
    .toRouting  (toRouting)
  );

endmodule

// File: tb/iocell_top_bench.sv
`timescale 1ns/1ps
module iocell_top_bench;

  localparam int NT = 8;

  logic ioClk0 = 1'b0;
  logic ioClk1 = 1'b0;
  logic rstN = 1'b1;
  logic routedData = 1'b0, bypassData = 1'b0, goe0 = 1'b0, goe1 = 1'b0;
  logic [NT-1:0] ptOeTerms = '0;
  logic cfgUseBypass = 1'b0, cfgInvert = 1'b0, cfgOpenDrain = 1'b0, cfgClkSel = 1'b0;
  logic [2:0] cfgOeSel = 3'd0;
  logic [2:0] cfgPtSel = 3'd0;
  logic [1:0] cfgInMode = 2'd0;
  logic padIn = 1'b0;
  logic padOut, padOe, toRouting;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic expEdge = 1'b0;
  logic expLevel = 1'b0;

  iocell_top u_iocell_top (
    .ioClk0(ioClk0), .ioClk1(ioClk1), .rstN(rstN),
    .routedData(routedData), .bypassData(bypassData),
    .ptOeTerms(ptOeTerms), .goe0(goe0), .goe1(goe1),
    .cfgUseBypass(cfgUseBypass), .cfgInvert(cfgInvert), .cfgOpenDrain(cfgOpenDrain),
    .cfgOeSel(cfgOeSel), .cfgPtSel(cfgPtSel), .cfgClkSel(cfgClkSel),
    .cfgInMode(cfgInMode), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .toRouting(toRouting)
  );

  // 125 MHz: high on [8k+4, 8k+8)
  always #4 ioClk0 = ~ioClk0;
  // second clock: high on [16k+5, 16k+9); both clocks low at 8k+2 and 8k+3
  initial forever begin
    #5 ioClk1 = 1'b1;
    #4 ioClk1 = 1'b0;
    #7;
  end

  // reference storage, from R8, R9, R10
  always @(posedge ioClk0 or negedge rstN)
    if (!rstN) expEdge <= 1'b0; else if (!cfgClkSel) expEdge <= padIn;
  always @(posedge ioClk1)
    if (rstN && cfgClkSel) expEdge <= padIn;
  always @(negedge ioClk0)
    if (rstN && !cfgClkSel) expLevel <= padIn;
  always @(negedge ioClk1)
    if (rstN && cfgClkSel) expLevel <= padIn;
  always @(negedge rstN) expLevel <= 1'b0;

  function automatic logic fnOe();
    case (cfgOeSel)
      3'd1: return 1'b1;
      3'd2: return ptOeTerms[cfgPtSel];
      3'd3: return goe0;
      3'd4: return goe1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic fnData();
    return (cfgUseBypass ? bypassData : routedData) ^ cfgInvert;
  endfunction

  function automatic logic fnPadOut();
    return cfgOpenDrain ? 1'b0 : fnData();
  endfunction

  function automatic logic fnPadOe();
    return cfgOpenDrain ? (fnOe() & ~fnData()) : fnOe();
  endfunction

  function automatic logic fnRouting();
    if (cfgInMode == 2'd1) return rstN ? expEdge : 1'b0;
    if (cfgInMode == 2'd2) return rstN ? expLevel : 1'b0;
    return padIn;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " R1 R2 R5 R6 padOut"}, padOut, fnPadOut());
    check({tag, " R3 R4 R5 R6 padOe"}, padOe, fnPadOe());
    check({tag, " R7 R8 R9 R10 R11 toRouting"}, toRouting, fnRouting());
  endtask

  task automatic toSlot();
    @(negedge ioClk0);
    #2;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C0DE));
    #1 rstN = 1'b0;
    cfgInMode = 2'd1;
    #1;
    check("R10 reset edge", toRouting, 1'b0);
    cfgInMode = 2'd2;
    #1;
    check("R10 reset level", toRouting, 1'b0);
    toSlot();
    rstN = 1'b1;

    // R1/R2: data source and polarity, totem-pole enabled
    cfgOeSel = 3'd1; routedData = 1'b1; bypassData = 1'b0;
    #1 check("R1 routed", padOut, 1'b1);
    cfgUseBypass = 1'b1;
    #1 check("R1 bypass", padOut, 1'b0);
    cfgInvert = 1'b1;
    #1 check("R2 invert", padOut, 1'b1);

    // R6: open-drain releases on high data, drives on low
    cfgOpenDrain = 1'b1;
    #1 check("R6 od high released", padOe, 1'b0);
    bypassData = 1'b1;
    #1 check("R6 od low driven", padOe, 1'b1);
    check("R6 od out", padOut, 1'b0);
    cfgOpenDrain = 1'b0; cfgInvert = 1'b0;

    // R4: each group term index
    cfgOeSel = 3'd2;
    for (int i = 0; i < NT; i++) begin
      ptOeTerms = 8'(1 << i);
      cfgPtSel = 3'(i);
      #1 check("R4 group term hit", padOe, 1'b1);
      cfgPtSel = 3'((i + 1) % NT);
      #1 check("R4 group term miss", padOe, 1'b0);
    end

    // R3: unused codes are off
    for (int c = 5; c < 8; c++) begin
      cfgOeSel = 3'(c);
      #1 check("R3 unused code", padOe, 1'b0);
    end

    // R11: readback while driving
    cfgOeSel = 3'd1; cfgInMode = 2'd0;
    padIn = ~padOut;
    #1 check("R11 readback", toRouting, padIn);

    // R9: latch transparency on clock 0
    toSlot();
    cfgInMode = 2'd2; cfgClkSel = 1'b0; padIn = 1'b0;
    @(posedge ioClk0); #1;
    padIn = 1'b1;
    #1 check("R9 transparent", toRouting, 1'b1);
    @(negedge ioClk0); #1;
    padIn = 1'b0;
    #1 check("R9 hold", toRouting, 1'b1);

    // R8: edge register ignores changes while clock high
    cfgInMode = 2'd1;
    @(posedge ioClk0); #1;
    padIn = 1'b1;
    #1 check("R8 no capture mid-high", toRouting, 1'b0);
    @(posedge ioClk0); #1;
    check("R8 capture at edge", toRouting, 1'b1);

    // R10: clear mid-run
    toSlot();
    rstN = 1'b0;
    #1 check("R10 async clear", toRouting, 1'b0);
    toSlot();
    rstN = 1'b1;

    // random mix
    for (int v = 0; v < 600; v++) begin
      toSlot();
      routedData   = 1'($urandom);
      bypassData   = 1'($urandom);
      ptOeTerms    = 8'($urandom);
      goe0         = 1'($urandom);
      goe1         = 1'($urandom);
      cfgUseBypass = 1'($urandom);
      cfgInvert    = 1'($urandom);
      cfgOpenDrain = 1'($urandom);
      cfgOeSel     = 3'($urandom);
      cfgPtSel     = 3'($urandom);
      if (($urandom % 8) == 0) cfgClkSel = ~cfgClkSel;
      if (($urandom % 4) == 0) cfgInMode = 2'($urandom);
      padIn        = 1'($urandom);
      rstN         = (($urandom % 32) != 0);
      #1 checkAll("rand");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule